// File: doc/BRIEF.md
# Reconfigurable Priority Concentrator Grid

This block is a grid of two-way switch elements with `ROWS` rows and `COLS` columns. It gathers the cells headed for one output group onto a small set of output links. In each time slot, one cell enters at the left end of every row, and one broadcast cell enters at the top of every column. Every element either lets its two cells pass straight on or swaps their directions. An element swaps when the cell arriving from the left beats the cell arriving from above: both must be valid, carry the same filtering address, and the left cell must hold the strictly higher priority. The cells that leave the bottoms of the columns form the output links. The cells that leave the right ends of the rows are the discards.

Each element has two run-time overrides: force-cross and force-toggle. They are loaded one element at a time through a write port that takes a row and column index. With them, a whole column can be made transparent to mask a vertical fault, or part of a column can be made transparent to step around a horizontal fault. A per-element fault-injection input models stuck-cross, stuck-toggle, vertical-stuck and horizontal-stuck elements for test benches. The whole slot (all row cells and all column cells together) is one transfer on a valid/ready input. The resolved slot is held in one output register, behind a valid/ready output. The output may stall the input: a held result blocks new slots until the downstream side takes it.

Top module: `pce_array`

## Requirements
- R1: After reset, `out_vld` is 0, `in_rdy` is 1, and no overrides are active.
- R2: With no override and no fault, an element swaps its cells only when both cells are valid, their filtering addresses are equal, and the left cell's priority is strictly greater than the top cell's priority. In every other case it passes them straight on.
- R3: Cells are packed as {valid[12], filtering address[11:8], priority[7:4], source[3:0]}. Row i occupies lane i of `row_cells` and `drop_cells`, and column j occupies lane j of `col_cells` and `link_cells` (lane k = bits k*13 and up). A cell that leaves the bottom of column j appears on link lane j. A cell that leaves the right end of row i appears on drop lane i.
- R4: Cells are moved whole and never altered. An invalid cell never causes a swap and leaves the grid still invalid. Without faults, the number of valid cells out equals the number of valid cells in.
- R5: Force-toggle on an element makes it swap regardless of the cells.
- R6: Force-cross on an element makes it pass straight on regardless of the cells.
- R7: When both overrides are set on one element, force-toggle wins.
- R8: With force-cross set on every element of column j, link lane j carries column j's top cell unchanged.
- R9: A write (`ovr_we`=1) at in-range (`ovr_row`, `ovr_col`) loads that element's two override bits from `ovr_tog`/`ovr_crs` and leaves all others unchanged. A write with an index at or beyond `ROWS`/`COLS` changes nothing.
- R10: `fault_inj` holds 3 bits per element at (row*COLS+col)*3: 0 none, 1 stuck-cross, 2 stuck-toggle, 3 vertical-stuck (the downward cell leaves invalid), 4 horizontal-stuck (the rightward cell leaves invalid). A stuck state beats any override.
- R11: `in_rdy` is 0 exactly while `out_vld` is 1 and `out_rdy` is 0. While stalled, `out_vld`, `link_cells` and `drop_cells` hold steady.
- R12: A slot accepted on a clock edge (`in_vld` and `in_rdy` high) appears on the outputs with `out_vld`=1 right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Slot offered |
| in_rdy | output | 1 | Slot can be taken |
| row_cells | input | ROWS*13 | Cells entering from the left, one lane per row |
| col_cells | input | COLS*13 | Broadcast cells entering from the top, one lane per column |
| ovr_we | input | 1 | Override write strobe |
| ovr_row | input | clog2(ROWS+1) | Row index of override write |
| ovr_col | input | clog2(COLS+1) | Column index of override write |
| ovr_tog | input | 1 | Force-toggle value to load |
| ovr_crs | input | 1 | Force-cross value to load |
| fault_inj | input | ROWS*COLS*3 | Per-element fault model code |
| out_vld | output | 1 | Resolved slot present |
| out_rdy | input | 1 | Downstream takes the slot |
| link_cells | output | COLS*13 | Cells at the column bottoms |
| drop_cells | output | ROWS*13 | Cells at the row right ends |

## Verification
A wrong element decision shows up in the same slot's result, one cycle after acceptance. Either a cell lands on the wrong link or drop lane, or the valid-cell count is no longer conserved. A corrupted override register stays silent until a slot contains cells whose route crosses that element. Random slots with narrow address and priority ranges therefore exercise many swaps, and column-isolation and partial-bypass patterns are then checked lane by lane. A broken stall path shows up as output data that changes while `out_rdy` is low, or as a slot that is lost or accepted while the output is held.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam int FA_W   = 4;
  localparam int PRI_W  = 4;
  localparam int SRC_W  = 4;
  localparam int CELL_W = 1 + FA_W + PRI_W + SRC_W;

  typedef struct packed {
    logic             vld;
    logic [FA_W-1:0]  fa;
    logic [PRI_W-1:0] pri;
    logic [SRC_W-1:0] src;
  } cell_t;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_SC   = 3'd1,
    FLT_ST   = 3'd2,
    FLT_VS   = 3'd3,
    FLT_HS   = 3'd4
  } fault_e;
endpackage

// File: rtl/pce_elem.sv
module pce_elem
  import pce_pkg::*;
(
  input  cell_t      h_in,
  input  cell_t      v_in,
  input  logic       frc_tog,
  input  logic       frc_crs,
  input  logic [2:0] flt,
  output cell_t      h_out,
  output cell_t      v_out
);
  logic wins;
  logic swap;

  always_comb begin
    wins = h_in.vld && v_in.vld && (h_in.fa == v_in.fa) && (h_in.pri > v_in.pri);
    case (fault_e'(flt))
      FLT_SC:  swap = 1'b0;
      FLT_ST:  swap = 1'b1;
      default: swap = frc_tog ? 1'b1 : (frc_crs ? 1'b0 : wins);
    endcase
    v_out = swap ? h_in : v_in;
    h_out = swap ? v_in : h_in;
    if (fault_e'(flt) == FLT_VS) v_out.vld = 1'b0;
    if (fault_e'(flt) == FLT_HS) h_out.vld = 1'b0;
  end
endmodule

// File: rtl/pce_ovr_regs.sv
module pce_ovr_regs #(
  parameter int ROWS = 6,
  parameter int COLS = 3,
  localparam int RIW = $clog2(ROWS + 1),
  localparam int CIW = $clog2(COLS + 1),
  localparam int NE  = ROWS * COLS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [RIW-1:0] row,
  input  logic [CIW-1:0] col,
  input  logic           tog,
  input  logic           crs,
  output logic [NE-1:0]  tog_q,
  output logic [NE-1:0]  crs_q
);
  for (genvar r = 0; r < ROWS; r++) begin : g_r
    for (genvar c = 0; c < COLS; c++) begin : g_c
      logic hit;
      assign hit = we && (row == RIW'(r)) && (col == CIW'(c));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          tog_q[r*COLS+c] <= 1'b0;
          crs_q[r*COLS+c] <= 1'b0;
        end else if (hit) begin
          tog_q[r*COLS+c] <= tog;
          crs_q[r*COLS+c] <= crs;
        end
      end
    end
  end
endmodule

// File: rtl/pce_array.sv
module pce_array
  import pce_pkg::*;
#(
  parameter int ROWS = 6,
  parameter int COLS = 3,
  localparam int RIW = $clog2(ROWS + 1),
  localparam int CIW = $clog2(COLS + 1),
  localparam int CW  = CELL_W,
  localparam int NE  = ROWS * COLS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  output logic              in_rdy,
  input  logic [ROWS*CW-1:0] row_cells,
  input  logic [COLS*CW-1:0] col_cells,
  input  logic              ovr_we,
  input  logic [RIW-1:0]    ovr_row,
  input  logic [CIW-1:0]    ovr_col,
  input  logic              ovr_tog,
  input  logic              ovr_crs,
  input  logic [NE*3-1:0]   fault_inj,
  output logic              out_vld,
  input  logic              out_rdy,
  output logic [COLS*CW-1:0] link_cells,
  output logic [ROWS*CW-1:0] drop_cells
);
  logic [NE-1:0] tog_q;
  logic [NE-1:0] crs_q;

  pce_ovr_regs #(.ROWS(ROWS), .COLS(COLS)) u_ovr (
    .clk(clk), .rst_n(rst_n), .we(ovr_we), .row(ovr_row), .col(ovr_col),
    .tog(ovr_tog), .crs(ovr_crs), .tog_q(tog_q), .crs_q(crs_q)
  );

  cell_t h_w [ROWS][COLS+1];
  cell_t v_w [ROWS+1][COLS];
  logic [COLS*CW-1:0] link_d;
  logic [ROWS*CW-1:0] drop_d;

  for (genvar r = 0; r < ROWS; r++) begin : g_rin
    assign h_w[r][0] = cell_t'(row_cells[r*CW +: CW]);
    assign drop_d[r*CW +: CW] = h_w[r][COLS];
  end
  for (genvar c = 0; c < COLS; c++) begin : g_cin
    assign v_w[0][c] = cell_t'(col_cells[c*CW +: CW]);
    assign link_d[c*CW +: CW] = v_w[ROWS][c];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      pce_elem u_e (
        .h_in   (h_w[r][c]),
        .v_in   (v_w[r][c]),
        .frc_tog(tog_q[r*COLS+c]),
        .frc_crs(crs_q[r*COLS+c]),
        .flt    (fault_inj[(r*COLS+c)*3 +: 3]),
        .h_out  (h_w[r][c+1]),
        .v_out  (v_w[r+1][c])
      );
    end
  end

  assign in_rdy = !out_vld || out_rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld    <= 1'b0;
      link_cells <= '0;
      drop_cells <= '0;
    end else if (in_rdy) begin
      out_vld <= in_vld;
      if (in_vld) begin
        link_cells <= link_d;
        drop_cells <= drop_d;
      end
    end
  end
endmodule

// File: rtl/pce_array_chk.sv
module pce_array_chk
  import pce_pkg::*;
#(
  parameter int ROWS = 6,
  parameter int COLS = 3,
  localparam int CW  = CELL_W,
  localparam int NE  = ROWS * COLS
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_vld,
  input logic               in_rdy,
  input logic [ROWS*CW-1:0] row_cells,
  input logic [COLS*CW-1:0] col_cells,
  input logic [NE*3-1:0]    fault_inj,
  input logic               out_vld,
  input logic               out_rdy,
  input logic [COLS*CW-1:0] link_cells,
  input logic [ROWS*CW-1:0] drop_cells
);
  logic [ROWS-1:0] rin_v, drp_v;
  logic [COLS-1:0] cin_v, lnk_v;
  for (genvar r = 0; r < ROWS; r++) begin : g_r
    assign rin_v[r] = row_cells[r*CW + CW - 1];
    assign drp_v[r] = drop_cells[r*CW + CW - 1];
  end
  for (genvar c = 0; c < COLS; c++) begin : g_c
    assign cin_v[c] = col_cells[c*CW + CW - 1];
    assign lnk_v[c] = link_cells[c*CW + CW - 1];
  end

  // R4
  valid_conserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_rdy && fault_inj == '0) |=>
      ($countones({lnk_v, drp_v}) == $past($countones({rin_v, cin_v}))));

  // R11
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_rdy) |-> !in_rdy);

  // R11
  stall_holds_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_rdy) |=> (out_vld && $stable(link_cells) && $stable(drop_cells)));

  // R12
  accept_shows_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_rdy) |=> out_vld);

  // R11
  no_drop_unread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_vld) |-> $past(out_rdy));
endmodule

bind pce_array pce_array_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(in_rdy),
  .row_cells(row_cells), .col_cells(col_cells), .fault_inj(fault_inj),
  .out_vld(out_vld), .out_rdy(out_rdy), .link_cells(link_cells),
  .drop_cells(drop_cells)
);

// File: tb/sim_pce_array.sv
`timescale 1ns/1ps
module sim_pce_array;
  import pce_pkg::*;
  localparam int ROWS = 6;
  localparam int COLS = 3;
  localparam int CW   = CELL_W;
  localparam int NE   = ROWS * COLS;
  localparam int RIW  = $clog2(ROWS + 1);
  localparam int CIW  = $clog2(COLS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic in_rdy;
  logic [ROWS*CW-1:0] row_cells = '0;
  logic [COLS*CW-1:0] col_cells = '0;
  logic ovr_we = 1'b0;
  logic [RIW-1:0] ovr_row = '0;
  logic [CIW-1:0] ovr_col = '0;
  logic ovr_tog = 1'b0, ovr_crs = 1'b0;
  logic [NE*3-1:0] fault_inj = '0;
  logic out_vld;
  logic out_rdy = 1'b1;
  logic [COLS*CW-1:0] link_cells;
  logic [ROWS*CW-1:0] drop_cells;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  bit m_tog [NE];
  bit m_crs [NE];

  always #2 clk = ~clk;

  pce_array #(.ROWS(ROWS), .COLS(COLS)) u0 (.*);

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void elem_m(input cell_t h, input cell_t v, input int idx,
                                 output cell_t ho, output cell_t vo);
    bit t;
    logic [2:0] f;
    f = fault_inj[idx*3 +: 3];
    t = h.vld && v.vld && h.fa == v.fa && h.pri > v.pri;
    if (m_crs[idx]) t = 0;
    if (m_tog[idx]) t = 1;
    if (f == 3'd1) t = 0;
    if (f == 3'd2) t = 1;
    ho = t ? v : h;
    vo = t ? h : v;
    if (f == 3'd3) vo.vld = 1'b0;
    if (f == 3'd4) ho.vld = 1'b0;
  endfunction

  function automatic void model(output logic [COLS*CW-1:0] lk, output logic [ROWS*CW-1:0] dr);
    cell_t vc [COLS];
    cell_t hc, ho, vo;
    for (int c = 0; c < COLS; c++) vc[c] = cell_t'(col_cells[c*CW +: CW]);
    for (int r = 0; r < ROWS; r++) begin
      hc = cell_t'(row_cells[r*CW +: CW]);
      for (int c = 0; c < COLS; c++) begin
        elem_m(hc, vc[c], r*COLS+c, ho, vo);
        hc = ho;
        vc[c] = vo;
      end
      dr[r*CW +: CW] = hc;
    end
    for (int c = 0; c < COLS; c++) lk[c*CW +: CW] = vc[c];
  endfunction

  function automatic cell_t rnd_cell(int src);
    cell_t x;
    x.vld = ($urandom_range(0, 3) != 0);
    x.fa  = FA_W'($urandom_range(0, 1));
    x.pri = PRI_W'($urandom_range(0, 15));
    x.src = SRC_W'(src);
    return x;
  endfunction

  task automatic rnd_inputs();
    for (int r = 0; r < ROWS; r++) row_cells[r*CW +: CW] = rnd_cell(r);
    for (int c = 0; c < COLS; c++) col_cells[c*CW +: CW] = rnd_cell(c);
  endtask

  task automatic wr_ovr(int r, int c, bit t, bit x);
    @(negedge clk);
    ovr_we = 1; ovr_row = RIW'(r); ovr_col = CIW'(c); ovr_tog = t; ovr_crs = x;
    if (r < ROWS && c < COLS) begin m_tog[r*COLS+c] = t; m_crs[r*COLS+c] = x; end
    @(negedge clk);
    ovr_we = 0;
  endtask

  task automatic clear_ovr();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) wr_ovr(r, c, 0, 0);
  endtask

  task automatic slot(string req);
    logic [COLS*CW-1:0] lk;
    logic [ROWS*CW-1:0] dr;
    @(negedge clk);
    in_vld = 1;
    model(lk, dr);
    @(posedge clk);
    @(negedge clk);
    in_vld = 0;
    chk({req, " R12 out_vld"}, 128'(out_vld), 128'(1));
    chk({req, " links"}, 128'(link_cells), 128'(lk));
    chk({req, " drops"}, 128'(drop_cells), 128'(dr));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [COLS*CW-1:0] held_l;
    logic [ROWS*CW-1:0] held_d;
    cell_t a, b;
    void'($urandom(32'h00c0ffee));
    for (int i = 0; i < NE; i++) begin m_tog[i] = 0; m_crs[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    chk("R1 out_vld", 128'(out_vld), 128'(0));
    chk("R1 in_rdy", 128'(in_rdy), 128'(1));

    // R4 all invalid
    row_cells = '0; col_cells = '0;
    slot("R4 empty");

    // R2 equal priority crosses, higher priority swaps (R3 lane placement)
    a = '{vld:1'b1, fa:4'd3, pri:4'd5, src:4'd0};
    b = '{vld:1'b1, fa:4'd3, pri:4'd5, src:4'd0};
    row_cells = '0; col_cells = '0;
    row_cells[0 +: CW] = a; col_cells[0 +: CW] = b;
    slot("R2 equal");
    chk("R2 equal link0", 128'(link_cells[0 +: CW]), 128'(b));
    a.pri = 4'd6;
    row_cells[0 +: CW] = a;
    slot("R2 higher");
    chk("R3 higher link0", 128'(link_cells[0 +: CW]), 128'(a));
    chk("R3 higher drop0", 128'(drop_cells[0 +: CW]), 128'(b));
    a.fa = 4'd2;
    row_cells[0 +: CW] = a;
    slot("R2 addr mismatch");
    chk("R2 mismatch link0", 128'(link_cells[0 +: CW]), 128'(b));

    // R2 R3 R4 random patterns
    for (int n = 0; n < 150; n++) begin rnd_inputs(); slot("R2 random"); end

    // R5 R6 R7 random overrides
    for (int k = 0; k < 8; k++)
      wr_ovr($urandom_range(0, ROWS-1), $urandom_range(0, COLS-1),
             bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    wr_ovr(1, 1, 1, 1); // R7 both set
    wr_ovr(0, 2, 1, 0); // R5
    wr_ovr(3, 0, 0, 1); // R6
    for (int n = 0; n < 60; n++) begin rnd_inputs(); slot("R5 R6 R7 overrides"); end

    // R9 out-of-range writes change nothing
    wr_ovr(ROWS, 0, 1, 0);
    wr_ovr(0, COLS, 1, 0);
    for (int n = 0; n < 20; n++) begin rnd_inputs(); slot("R9 out of range"); end
    clear_ovr();

    // R8 column isolation
    for (int r = 0; r < ROWS; r++) wr_ovr(r, 1, 0, 1);
    for (int n = 0; n < 40; n++) begin
      rnd_inputs();
      slot("R8 isolate");
      chk("R8 link1", 128'(link_cells[CW +: CW]), 128'(col_cells[CW +: CW]));
    end
    clear_ovr();

    // R10 horizontal-stuck bypass at (2,1)
    fault_inj[(2*COLS+1)*3 +: 3] = 3'd4;
    wr_ovr(2, 1, 1, 0);
    wr_ovr(0, 1, 0, 1);
    wr_ovr(1, 1, 0, 1);
    for (int n = 0; n < 30; n++) begin rnd_inputs(); slot("R10 hs bypass"); end
    clear_ovr();

    // R10 random faults, stuck beats overrides
    for (int n = 0; n < 60; n++) begin
      for (int i = 0; i < NE; i++) fault_inj[i*3 +: 3] = 3'($urandom_range(0, 4));
      if (n == 0) wr_ovr(0, 0, 1, 0);
      rnd_inputs();
      slot("R10 faults");
    end
    fault_inj = '0;
    clear_ovr();

    // R11 back-pressure
    @(negedge clk);
    out_rdy = 0;
    rnd_inputs();
    slot("R11 first");
    held_l = link_cells; held_d = drop_cells;
    chk("R11 in_rdy low", 128'(in_rdy), 128'(0));
    rnd_inputs();
    in_vld = 1;
    @(posedge clk); @(negedge clk);
    chk("R11 held links", 128'(link_cells), 128'(held_l));
    chk("R11 held drops", 128'(drop_cells), 128'(held_d));
    chk("R11 held vld", 128'(out_vld), 128'(1));
    begin
      logic [COLS*CW-1:0] lk;
      logic [ROWS*CW-1:0] dr;
      model(lk, dr);
      out_rdy = 1;
      @(posedge clk); @(negedge clk);
      in_vld = 0;
      chk("R11 second links", 128'(link_cells), 128'(lk));
      chk("R11 second drops", 128'(drop_cells), 128'(dr));
    end
    @(posedge clk); @(negedge clk);
    chk("R11 drained", 128'(out_vld), 128'(0));

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule